// File: doc/BRIEF.md
# Countdown Timer Bank

A register-mapped peripheral that holds four independent 32-bit countdown timers behind a simple synchronous register bus. One shared control word sets three things for each timer: whether it runs, whether it restarts from its reload register after reaching zero, and whether it steps on every core clock or only on cycles where a 25 MHz tick-enable input is high. Each timer has a reload register and a live count register, and software can write both.

Software sets up a timer by writing its reload and count registers and then setting its run and restart bits. With restart on and a reload value of all ones, the timer counts freely over its full range with no further software action. Each timer drives its own expiry line. The line pulses for one clock on the step that takes the count from 1 to 0. An interrupt controller or a polling loop can use it.

Top module: `ctd_timer_bank`

## Requirements
- R1: After reset, the control word, every reload register and every count register read zero, and every expiry line is low.
- R2: The control word is at byte address 0x00. Timer n's reload register is at 0x10 + 8n and its count register is at 0x14 + 8n (n = 0..3). Written values read back, and any other address reads zero.
- R3: In the control word, bit 2n runs timer n, bit 2n+1 turns on restart for timer n, and bit n+11 selects the tick-enable source for timer n. Every other bit reads zero, so writing all ones reads back 0x000078FF.
- R4: A running timer with source select 0 decrements by one on every core clock. A stopped timer holds its count.
- R5: A running timer with source select 1 decrements only on clocks where tick25_i is high.
- R6: With restart on, a step taken at count 0 loads the reload register, so the expiry period is reload+1 steps. A reload of 0xFFFFFFFF wraps 0 to 0xFFFFFFFF.
- R7: With restart off, a timer that reaches 0 stays at 0.
- R8: expire_o[n] is high for exactly one clock, the clock after the edge where timer n's count stepped from 1 to 0. This holds with restart on or off.
- R9: Writing a reload register leaves the running count undisturbed.
- R10: When a bus write to a count register falls on the same edge as a step of that timer, the written value wins.
- R11: Writes to the three words at 0x04, 0x08 and 0x0C are ignored, and those words read zero.
- R12: A read asserted at an edge returns the count as it stood before that edge's step. rdata_o holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| tick25_i | input | 1 | 25 MHz tick enable |
| expire_o | output | 4 | Per-timer expiry pulse |

## Verification
A bus write to a count register and that timer's own decrement can land on the same clock edge. The bench sets this up by starting a timer on the core clock and writing a new count to it while it runs, so the write and the step share an edge. It then reads the count on the next two edges. It expects the written value first and then one less, which shows that the step taken on the write's edge was dropped.

// File: rtl/ctd_pkg.sv
package ctd_pkg;
  typedef enum logic [1:0] {FLD_NONE, FLD_CTRL, FLD_RLD, FLD_VAL} ctd_fld_e;
  localparam int unsigned CTD_SEL_BASE = 11;
  localparam int unsigned CTD_CH_BASE  = 16;
  localparam int unsigned CTD_CH_STEP  = 8;
endpackage

// File: rtl/ctd_addr_dec.sv
module ctd_addr_dec import ctd_pkg::*; #(
  parameter int unsigned AW   = 8,
  parameter int unsigned N    = 4,
  localparam int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [AW-1:0]   addr_i,
  output ctd_fld_e        fld_o,
  output logic [IDXW-1:0] idx_o
);
  localparam int unsigned LAST = CTD_CH_BASE + CTD_CH_STEP * N;

  always_comb begin
    fld_o = FLD_NONE;
    idx_o = IDXW'((32'(addr_i) - CTD_CH_BASE) >> 3);
    if (32'(addr_i) == 32'd0)
      fld_o = FLD_CTRL;
    else if (32'(addr_i) >= CTD_CH_BASE && 32'(addr_i) < LAST && addr_i[1:0] == 2'b00)
      fld_o = addr_i[2] ? FLD_VAL : FLD_RLD;
  end
endmodule

// File: rtl/ctd_ctrl_reg.sv
module ctd_ctrl_reg import ctd_pkg::*; #(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [N-1:0]  en_d_i,
  input  logic [N-1:0]  auto_d_i,
  input  logic [N-1:0]  sel_d_i,
  output logic [N-1:0]  en_o,
  output logic [N-1:0]  auto_o,
  output logic [N-1:0]  sel_o,
  output logic [DW-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      auto_o <= '0;
      sel_o  <= '0;
    end else if (wr_i) begin
      en_o   <= en_d_i;
      auto_o <= auto_d_i;
      sel_o  <= sel_d_i;
    end
  end

  always_comb begin
    word_o = '0;
    for (int n = 0; n < N; n++) begin
      word_o[2*n]              = en_o[n];
      word_o[2*n+1]            = auto_o[n];
      word_o[CTD_SEL_BASE + n] = sel_o[n];
    end
  end

  // R3: control bits change only through a control-word write
  a_r3_ctrl_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(en_o) && $stable(auto_o) && $stable(sel_o)));
endmodule

// File: rtl/ctd_chan.sv
module ctd_chan #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          auto_i,
  input  logic          sel_i,
  input  logic          tick25_i,
  input  logic          wr_val_i,
  input  logic          wr_rld_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] rld_o,
  output logic          expire_o
);
  logic step;
  assign step = en_i & (sel_i ? tick25_i : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      rld_o    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= step & ~wr_val_i & (cnt_o == DW'(1));
      if (wr_rld_i) rld_o <= wdata_i;
      if (wr_val_i) cnt_o <= wdata_i;  // bus write beats the step
      else if (step) begin
        if (cnt_o != '0)  cnt_o <= cnt_o - DW'(1);
        else if (auto_i) cnt_o <= rld_o;
      end
    end
  end

  a_r4_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !wr_val_i && cnt_o != '0) |=> cnt_o == $past(cnt_o) - DW'(1));
  a_r4_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step && !wr_val_i) |=> $stable(cnt_o));
  a_r6_reload_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !wr_val_i && auto_i && cnt_o == '0) |=> cnt_o == $past(rld_o));
  a_r7_stay_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_i && !wr_val_i && cnt_o == '0) |=> cnt_o == '0);
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
  a_r8_pulse_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> cnt_o == '0);
  a_r9_reload_no_touch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rld_i && !wr_val_i && !step) |=> $stable(cnt_o));
  a_r10_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_val_i |=> cnt_o == $past(wdata_i));
endmodule

// File: rtl/ctd_timer_bank.sv
module ctd_timer_bank import ctd_pkg::*; #(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tick25_i,
  output logic [N-1:0]  expire_o
);
  localparam int unsigned IDXW = (N > 1) ? $clog2(N) : 1;

  ctd_fld_e        fld;
  logic [IDXW-1:0] idx;
  logic [N-1:0]    en, auto_rl, sel, en_d, auto_d, sel_d;
  logic [DW-1:0]   ctrl_word, rd_mux;
  logic [DW-1:0]   cnt_arr [N];
  logic [DW-1:0]   rld_arr [N];

  ctd_addr_dec #(.AW(AW), .N(N)) i_dec (
    .addr_i(addr_i), .fld_o(fld), .idx_o(idx)
  );

  for (genvar n = 0; n < N; n++) begin : g_ctrl_bits
    assign en_d[n]   = wdata_i[2*n];
    assign auto_d[n] = wdata_i[2*n+1];
    assign sel_d[n]  = wdata_i[CTD_SEL_BASE + n];
  end

  ctd_ctrl_reg #(.N(N), .DW(DW)) i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(we_i && fld == FLD_CTRL),
    .en_d_i(en_d), .auto_d_i(auto_d), .sel_d_i(sel_d),
    .en_o(en), .auto_o(auto_rl), .sel_o(sel), .word_o(ctrl_word)
  );

  for (genvar n = 0; n < N; n++) begin : g_chan
    logic hit;
    assign hit = we_i && (idx == IDXW'(n));
    ctd_chan #(.DW(DW)) i_chan (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .en_i(en[n]), .auto_i(auto_rl[n]), .sel_i(sel[n]), .tick25_i(tick25_i),
      .wr_val_i(hit && fld == FLD_VAL), .wr_rld_i(hit && fld == FLD_RLD),
      .wdata_i(wdata_i), .cnt_o(cnt_arr[n]), .rld_o(rld_arr[n]),
      .expire_o(expire_o[n])
    );
  end

  always_comb begin
    unique case (fld)
      FLD_CTRL: rd_mux = ctrl_word;
      FLD_RLD:  rd_mux = rld_arr[idx];
      FLD_VAL:  rd_mux = cnt_arr[idx];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  a_r12_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
  a_r11_pad_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i inside {AW'(4), AW'(8), AW'(12)}) |=> rdata_o == '0);
endmodule

// File: tb/test_ctd_timer_bank.sv
module test_ctd_timer_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0, tick25 = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  expire;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ctd_timer_bank i_ctd_timer_bank (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .tick25_i(tick25), .expire_o(expire)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  function automatic logic [7:0] rld_a(input int n); return 8'(16 + 8*n); endfunction
  function automatic logic [7:0] val_a(input int n); return 8'(20 + 8*n); endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int pulses, first;
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 expire", 32'(expire), 0);
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    for (int n = 0; n < 4; n++) begin
      rd(rld_a(n), d); chk("R1 reload", d, 0);
      rd(val_a(n), d); chk("R1 count", d, 0);
    end

    // R2 map and read-back, R4 stopped timers hold
    for (int n = 0; n < 4; n++) begin
      wr(rld_a(n), 32'h1000 + 32'(n) * 32'h11);
      wr(val_a(n), 32'hA000 + 32'(n));
    end
    idle(5);
    for (int n = 0; n < 4; n++) begin
      rd(rld_a(n), d); chk("R2 reload", d, 32'h1000 + 32'(n) * 32'h11);
      rd(val_a(n), d); chk("R4 stopped hold", d, 32'hA000 + 32'(n));
    end
    rd(8'h30, d); chk("R2 unmapped", d, 0);
    rd(8'h11, d); chk("R2 unaligned", d, 0);

    // R3 control bit positions
    for (int n = 0; n < 4; n++) begin
      wr(8'h00, 32'd1 << (2*n + 1)); rd(8'h00, d); chk("R3 restart bit", d, 32'd1 << (2*n + 1));
      wr(8'h00, 32'd1 << (11 + n));  rd(8'h00, d); chk("R3 select bit", d, 32'd1 << (11 + n));
      wr(8'h00, 32'd1 << (2*n));     rd(8'h00, d); chk("R3 run bit", d, 32'd1 << (2*n));
    end
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R3 mask", d, 32'h0000_78FF);
    wr(8'h00, 0);

    // R11 padding words
    for (int a = 4; a < 16; a += 4) begin
      wr(8'(a), 32'hFFFF_FFFF);
      rd(8'(a), d); chk("R11 pad read", d, 0);
    end
    rd(8'h00, d); chk("R11 ctrl untouched", d, 0);
    for (int n = 0; n < 4; n++) begin
      rd(rld_a(n), d); chk("R11 reload untouched", d, 32'h1000 + 32'(n) * 32'h11);
    end

    // R4 / R12 core-clock counting per timer
    for (int n = 0; n < 4; n++) begin
      wr(val_a(n), 32'd1000 + 32'(n));
      wr(8'h00, 32'd1 << (2*n));
      rd(val_a(n), d);  chk("R12 first read", d, 32'd1000 + 32'(n));
      rd(val_a(n), d);  chk("R4 step", d, 32'd999 + 32'(n));
      idle(3);
      rd(val_a(n), d);  chk("R4 five steps", d, 32'd995 + 32'(n));
      wr(8'h00, 0);
      rd(val_a(n), d);  chk("R4 stop", d, 32'd993 + 32'(n));
      idle(4);
      rd(val_a(n), d2); chk("R4 hold after stop", d2, d);
    end

    // R10 write and step on one edge
    wr(val_a(1), 500);
    wr(8'h00, 32'h4);
    idle(2);
    wr(val_a(1), 7777);
    rd(val_a(1), d); chk("R10 write wins", d, 7777);
    rd(val_a(1), d); chk("R10 resumes", d, 7776);
    wr(8'h00, 0);

    // R9 reload write while running
    wr(val_a(2), 300);
    wr(8'h00, 32'h10);
    rd(val_a(2), d); chk("R9 pre", d, 300);
    wr(rld_a(2), 32'hDEAD);
    rd(val_a(2), d); chk("R9 count undisturbed", d, 298);
    wr(8'h00, 0);
    rd(rld_a(2), d); chk("R9 reload stored", d, 32'hDEAD);

    // R7 / R8 one-shot expiry
    wr(val_a(3), 3);
    wr(8'h00, 32'd1 << 6);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk("R8 one-shot pulse", 32'(expire), (k == 3) ? 32'h8 : 32'h0);
    end
    rd(val_a(3), d); chk("R7 stays zero", d, 0);
    idle(4);
    rd(val_a(3), d); chk("R7 still zero", d, 0);
    wr(8'h00, 0);

    // R6 / R8 restart period sweep
    for (int r = 0; r <= 6; r++) begin
      automatic int n = r % 4;
      wr(rld_a(n), 32'(r));
      wr(val_a(n), 1);
      wr(8'h00, 32'd3 << (2*n));
      pulses = 0; first = 0;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (expire[n]) begin
          pulses++;
          if (first == 0) first = k;
        end
      end
      chk("R6 pulse count", 32'(pulses), (r == 0) ? 32'd1 : 32'(1 + 19 / (r + 1)));
      chk("R8 first pulse", 32'(first), 1);
      wr(8'h00, 0);
    end

    // R6 full-range wrap
    wr(rld_a(0), 32'hFFFF_FFFF);
    wr(val_a(0), 0);
    wr(8'h00, 32'h3);
    rd(val_a(0), d); chk("R6 at zero", d, 0);
    rd(val_a(0), d); chk("R6 wrap", d, 32'hFFFF_FFFF);
    rd(val_a(0), d); chk("R6 after wrap", d, 32'hFFFF_FFFE);
    wr(8'h00, 0);

    // R5 tick-enable source
    wr(val_a(0), 100);
    wr(8'h00, 32'h1 | (32'd1 << 11));
    idle(4);
    rd(val_a(0), d); chk("R5 no tick", d, 100);
    tick25 = 1'b1;
    idle(5);
    tick25 = 1'b0;
    rd(val_a(0), d); chk("R5 burst", d, 95);
    for (int k = 0; k < 6; k++) begin
      tick25 = 1'b1; @(negedge clk);
      tick25 = 1'b0; idle(2);
    end
    rd(val_a(0), d); chk("R5 sparse", d, 89);
    wr(8'h00, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule